// File: doc/BRIEF.md
# Nested Loop Counter Stack

This block is the loop-control unit of an instruction sequencer. It holds up to `DEPTH` nested loop frames (8 by default). Each frame keeps a remaining iteration count and the program address of the loop-opening instruction that created it. The sequencer strobes `loop_stb` when it executes a loop-opening instruction and `endloop_stb` when it executes a loop-closing instruction. In both cases it also presents the current program counter and the instruction's arguments.

A loop-opening instruction is executed again on every pass through the loop body. It opens a frame only when the top frame does not already belong to its own address. On later passes it recognises its own frame and leaves the stack untouched. A loop-closing instruction decrements the top frame's count. While passes remain, it steers the sequencer back to the target address it carries. On the last pass it pops the frame and lets execution fall through.

As a result, for a loop of count n, both the opening and the closing instruction run exactly n times. Misuse raises sticky error flags. Misuse means a zero count, one nesting level too many, or a close with nothing open. A synchronous reset empties the stack and clears the flags.

Top module: `loop_nest_stack`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge) the stack is empty, all three error flags are 0, and `branch_take` is 0; a following close strobe therefore raises `err_underflow`.
- R2: An open strobe whose `pc` differs from the top frame's address, or that arrives with an empty stack, with `count_arg` > 0 and fewer than `DEPTH` frames, pushes a frame holding `count_arg` and `pc`.
- R3: An open strobe whose `pc` equals the top frame's stored address changes no frame, whatever its `count_arg`.
- R4: A close strobe with a top frame count greater than 1 drives `branch_take` = 1 and `next_pc` = `target_arg` in the same cycle, and decrements that count at the clock edge.
- R5: A close strobe with a top frame count of 1 drives `branch_take` = 0 and `next_pc` = `pc` + 1 and pops the frame at the clock edge, so a later open strobe at the same address opens a fresh frame.
- R6: For an opening instruction of count n followed by a closing instruction that targets it, each runs exactly n times; this holds for nested loops too.
- R7: An open strobe that would push with `count_arg` = 0 pushes nothing and sets `err_zero`.
- R8: An open strobe that would push while `DEPTH` frames are held pushes nothing, leaves every frame unchanged and sets `err_overflow`.
- R9: A close strobe with an empty stack sets `err_underflow`, drives `branch_take` = 0 and `next_pc` = `pc` + 1, and changes no frame.
- R10: When both strobes are high in one cycle, only the open is acted on; the close is ignored and `branch_take` is 0.
- R11: Every error flag stays at 1 from the cycle after it is set until the next reset.
- R12: Only the top frame is compared; an open strobe at an address held in a lower frame pushes a new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pc | input | ADDR_W | Address of the instruction being executed |
| loop_stb | input | 1 | The current instruction opens a loop |
| endloop_stb | input | 1 | The current instruction closes a loop |
| count_arg | input | CNT_W | Iteration count for an open |
| target_arg | input | ADDR_W | Branch-back address for a close |
| branch_take | output | 1 | The close must jump back to `target_arg` |
| next_pc | output | ADDR_W | `target_arg` when branching, else `pc` + 1 |
| err_zero | output | 1 | Sticky: an open was attempted with a count of zero |
| err_overflow | output | 1 | Sticky: the nesting limit was exceeded |
| err_underflow | output | 1 | Sticky: a close arrived with no frame open |

## Verification
The hardest state to reach from the ports is a full stack whose top frame still has passes left. Only from there can a rejected ninth open be told apart from one that was wrongly accepted. The bench builds it directly: it opens eight loops at distinct addresses and then attempts a ninth. The following closes must then branch according to the eighth frame's count. The bench also runs a small program interpreter that follows `next_pc` through nested loops and counts how often each instruction executes. Random mixed strobes over a small address set make re-entry matches, lower-frame matches and error cases common, and they are checked against a bench model every cycle.

// File: rtl/loop_nest_pkg.sv
package loop_nest_pkg;

   typedef enum logic [1:0] {
      LN_IDLE  = 2'd0,
      LN_OPEN  = 2'd1,
      LN_CLOSE = 2'd2
   } ln_op_e;

   typedef enum logic [2:0] {
      ACT_NONE   = 3'd0,
      ACT_PUSH   = 3'd1,
      ACT_DEC    = 3'd2,
      ACT_POP    = 3'd3,
      ACT_REJECT = 3'd4
   } ln_act_e;

   // An open strobe wins over a simultaneous close strobe.
   function automatic ln_op_e ln_decode(input logic open_s, input logic close_s);
      if (open_s)
         return LN_OPEN;
      else if (close_s)
         return LN_CLOSE;
      else
         return LN_IDLE;
   endfunction

endpackage

// File: rtl/lns_decide.sv
module lns_decide
   import loop_nest_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int CNT_W  = 20,
   parameter int ADDR_W = 16,
   localparam int DW    = $clog2(DEPTH + 1)
) (
   input  logic              loop_stb,
   input  logic              endloop_stb,
   input  logic [ADDR_W-1:0] pc,
   input  logic [CNT_W-1:0]  count_arg,
   input  logic [ADDR_W-1:0] target_arg,
   input  logic [DW-1:0]     depth,
   input  logic [CNT_W-1:0]  top_cnt,
   input  logic [ADDR_W-1:0] top_addr,
   output ln_act_e           action,
   output logic              top_match,
   output logic              branch_take,
   output logic [ADDR_W-1:0] next_pc,
   output logic              set_zero,
   output logic              set_ovf,
   output logic              set_unf
);

   localparam logic [DW-1:0] FULL = DW'(DEPTH);

   ln_op_e op;
   logic   empty;
   logic   full;
   logic   last_pass;

   assign op        = ln_decode(loop_stb, endloop_stb);
   assign empty     = (depth == '0);
   assign full      = (depth == FULL);
   assign top_match = !empty && (top_addr == pc);
   assign last_pass = (top_cnt <= CNT_W'(1));

   always_comb begin
      action   = ACT_NONE;
      set_zero = 1'b0;
      set_ovf  = 1'b0;
      set_unf  = 1'b0;
      unique case (op)
         LN_OPEN: begin
            if (top_match) begin
               action = ACT_NONE;
            end else if (count_arg == '0) begin
               action   = ACT_REJECT;
               set_zero = 1'b1;
            end else if (full) begin
               action  = ACT_REJECT;
               set_ovf = 1'b1;
            end else begin
               action = ACT_PUSH;
            end
         end
         LN_CLOSE: begin
            if (empty) begin
               action  = ACT_REJECT;
               set_unf = 1'b1;
            end else if (last_pass) begin
               action = ACT_POP;
            end else begin
               action = ACT_DEC;
            end
         end
         default: action = ACT_NONE;
      endcase
   end

   assign branch_take = (action == ACT_DEC);
   assign next_pc     = branch_take ? target_arg : pc + ADDR_W'(1);

endmodule

// File: rtl/lns_frame_store.sv
module lns_frame_store
   import loop_nest_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int CNT_W  = 20,
   parameter int ADDR_W = 16,
   localparam int DW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  ln_act_e           action,
   input  logic [CNT_W-1:0]  push_cnt,
   input  logic [ADDR_W-1:0] push_addr,
   output logic [DW-1:0]     depth,
   output logic [CNT_W-1:0]  top_cnt,
   output logic [ADDR_W-1:0] top_addr
);

   logic [CNT_W-1:0]  cnt_q  [DEPTH];
   logic [ADDR_W-1:0] addr_q [DEPTH];
   logic [DW-1:0]     depth_q;

   always_ff @(posedge clk) begin
      if (rst)
         depth_q <= '0;
      else if (action == ACT_PUSH)
         depth_q <= depth_q + DW'(1);
      else if (action == ACT_POP)
         depth_q <= depth_q - DW'(1);
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic is_next;
      logic is_top;
      assign is_next = (depth_q == DW'(i));
      assign is_top  = (depth_q == DW'(i + 1));

      always_ff @(posedge clk) begin
         if (rst) begin
            cnt_q[i]  <= '0;
            addr_q[i] <= '0;
         end else if (action == ACT_PUSH && is_next) begin
            cnt_q[i]  <= push_cnt;
            addr_q[i] <= push_addr;
         end else if (action == ACT_DEC && is_top) begin
            cnt_q[i]  <= cnt_q[i] - CNT_W'(1);
         end
      end
   end

   always_comb begin
      top_cnt  = '0;
      top_addr = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (depth_q == DW'(i + 1)) begin
            top_cnt  = cnt_q[i];
            top_addr = addr_q[i];
         end
      end
   end

   assign depth = depth_q;

endmodule

// File: rtl/lns_err_flags.sv
module lns_err_flags #(
   parameter int NFLAG = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [NFLAG-1:0] set_i,
   output logic [NFLAG-1:0] flag_o
);

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      logic q;
      always_ff @(posedge clk) begin
         if (rst)
            q <= 1'b0;
         else if (set_i[i])
            q <= 1'b1;
      end
      assign flag_o[i] = q;
   end

endmodule

// File: rtl/loop_nest_stack.sv
module loop_nest_stack
   import loop_nest_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int CNT_W  = 20,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] pc,
   input  logic              loop_stb,
   input  logic              endloop_stb,
   input  logic [CNT_W-1:0]  count_arg,
   input  logic [ADDR_W-1:0] target_arg,
   output logic              branch_take,
   output logic [ADDR_W-1:0] next_pc,
   output logic              err_zero,
   output logic              err_overflow,
   output logic              err_underflow
);

   localparam int DW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("loop_nest_stack: DEPTH must be at least 2");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("loop_nest_stack: CNT_W must be at least 2");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("loop_nest_stack: ADDR_W must be at least 1");
   end

   ln_act_e           action;
   logic [DW-1:0]     depth_q;
   logic [CNT_W-1:0]  top_cnt;
   logic [ADDR_W-1:0] top_addr;
   logic              top_match;
   logic              set_zero, set_ovf, set_unf;
   logic [2:0]        flags;

   lns_decide #(
      .DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
   ) u_decide (
      .loop_stb    (loop_stb),
      .endloop_stb (endloop_stb),
      .pc          (pc),
      .count_arg   (count_arg),
      .target_arg  (target_arg),
      .depth       (depth_q),
      .top_cnt     (top_cnt),
      .top_addr    (top_addr),
      .action      (action),
      .top_match   (top_match),
      .branch_take (branch_take),
      .next_pc     (next_pc),
      .set_zero    (set_zero),
      .set_ovf     (set_ovf),
      .set_unf     (set_unf)
   );

   lns_frame_store #(
      .DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
   ) u_store (
      .clk       (clk),
      .rst       (rst),
      .action    (action),
      .push_cnt  (count_arg),
      .push_addr (pc),
      .depth     (depth_q),
      .top_cnt   (top_cnt),
      .top_addr  (top_addr)
   );

   lns_err_flags #(.NFLAG(3)) u_flags (
      .clk    (clk),
      .rst    (rst),
      .set_i  ({set_unf, set_ovf, set_zero}),
      .flag_o (flags)
   );

   assign err_zero      = flags[0];
   assign err_overflow  = flags[1];
   assign err_underflow = flags[2];

endmodule

// File: rtl/lns_checker.sv
module lns_checker #(
   parameter int DEPTH = 8,
   parameter int CNT_W = 20,
   localparam int DW   = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst,
   input logic             loop_stb,
   input logic             endloop_stb,
   input logic [CNT_W-1:0] count_arg,
   input logic             branch_take,
   input logic             err_zero,
   input logic             err_overflow,
   input logic             err_underflow,
   input logic [DW-1:0]    depth,
   input logic             top_match
);

   logic seen_clk;
   always_ff @(posedge clk) seen_clk <= 1'b1;

   always_comb begin
      if (seen_clk && !rst)
         AST_DEPTH_BOUND: assert (depth <= DW'(DEPTH)); // R8
   end

   AST_BRANCH_ONLY_CLOSE: assert property (@(posedge clk) disable iff (rst)
      branch_take |-> (endloop_stb && !loop_stb)); // R10

   AST_ZERO_STICKY: assert property (@(posedge clk) disable iff (rst)
      err_zero |=> err_zero); // R11
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
      err_overflow |=> err_overflow); // R11
   AST_UNF_STICKY: assert property (@(posedge clk) disable iff (rst)
      err_underflow |=> err_underflow); // R11

   AST_EMPTY_CLOSE: assert property (@(posedge clk) disable iff (rst)
      (endloop_stb && !loop_stb && depth == '0) |=> err_underflow); // R9

   AST_ZERO_OPEN: assert property (@(posedge clk) disable iff (rst)
      (loop_stb && !top_match && count_arg == '0) |=> (err_zero && $stable(depth))); // R7

   AST_REENTRY_HOLD: assert property (@(posedge clk) disable iff (rst)
      (loop_stb && top_match) |=> $stable(depth)); // R3

   AST_LAST_POP: assert property (@(posedge clk) disable iff (rst)
      (endloop_stb && !loop_stb && depth != '0 && !branch_take)
      |=> (depth == $past(depth) - DW'(1))); // R5

   AST_FULL_REJECT: assert property (@(posedge clk) disable iff (rst)
      (loop_stb && !top_match && count_arg != '0 && depth == DW'(DEPTH))
      |=> (err_overflow && $stable(depth))); // R8

endmodule

bind loop_nest_stack lns_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk           (clk),
   .rst           (rst),
   .loop_stb      (loop_stb),
   .endloop_stb   (endloop_stb),
   .count_arg     (count_arg),
   .branch_take   (branch_take),
   .err_zero      (err_zero),
   .err_overflow  (err_overflow),
   .err_underflow (err_underflow),
   .depth         (depth_q),
   .top_match     (top_match)
);

// File: tb/sim_loop_nest_stack.sv
`timescale 1ns/1ps
module sim_loop_nest_stack;

   localparam int DEPTH  = 8;
   localparam int CNT_W  = 20;
   localparam int ADDR_W = 16;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [ADDR_W-1:0] pc = '0;
   logic              loop_stb = 1'b0;
   logic              endloop_stb = 1'b0;
   logic [CNT_W-1:0]  count_arg = '0;
   logic [ADDR_W-1:0] target_arg = '0;
   logic              branch_take;
   logic [ADDR_W-1:0] next_pc;
   logic              err_zero, err_overflow, err_underflow;

   always #4 clk = ~clk;

   loop_nest_stack #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u0 (
      .clk(clk), .rst(rst), .pc(pc), .loop_stb(loop_stb), .endloop_stb(endloop_stb),
      .count_arg(count_arg), .target_arg(target_arg), .branch_take(branch_take),
      .next_pc(next_pc), .err_zero(err_zero), .err_overflow(err_overflow),
      .err_underflow(err_underflow)
   );

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // bench model of the stack
   int         m_dep;
   int         m_cnt  [DEPTH];
   int         m_addr [DEPTH];
   logic [2:0] m_err;

   task automatic check(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit exp_branch(input bit l, input bit e);
      return !l && e && m_dep > 0 && m_cnt[m_dep-1] > 1;
   endfunction

   function automatic string close_tag();
      if (m_dep == 0) return "R9 close on empty";
      if (m_cnt[m_dep-1] > 1) return "R4 close branches";
      return "R5 close falls through";
   endfunction

   task automatic model_apply(input bit l, input bit e, input int p, input int c);
      if (l) begin
         if (m_dep > 0 && m_addr[m_dep-1] == p) begin
         end else if (c == 0) m_err[0] = 1'b1;
         else if (m_dep == DEPTH) m_err[1] = 1'b1;
         else begin
            m_cnt[m_dep] = c; m_addr[m_dep] = p; m_dep++;
         end
      end else if (e) begin
         if (m_dep == 0) m_err[2] = 1'b1;
         else if (m_cnt[m_dep-1] > 1) m_cnt[m_dep-1]--;
         else m_dep--;
      end
   endtask

   // one instruction cycle; returns the observed branch flag
   task automatic step(input bit l, input bit e, input int p, input int c,
                       input int t, output bit br);
      string tag;
      bit    eb;
      @(negedge clk);
      loop_stb = l; endloop_stb = e; pc = ADDR_W'(p);
      count_arg = CNT_W'(c); target_arg = ADDR_W'(t);
      #1;
      eb  = exp_branch(l, e);
      tag = (l && e) ? "R10 both strobes" : (e ? close_tag() : "R2 open no branch");
      br  = branch_take;
      check({tag, " branch_take"}, branch_take, eb);
      check({tag, " next_pc"}, next_pc, eb ? t : ((p + 1) % (1 << ADDR_W)));
      model_apply(l, e, p, c);
      @(posedge clk); #1;
      check("R7 err_zero", err_zero, m_err[0]);
      check("R8 err_overflow", err_overflow, m_err[1]);
      check("R9 err_underflow", err_underflow, m_err[2]);
      loop_stb = 0; endloop_stb = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; loop_stb = 0; endloop_stb = 0;
      @(posedge clk); #1;
      rst = 1'b0;
      m_dep = 0; m_err = '0;
   endtask

   // program interpreter: op 0 plain, 1 open, 2 close, 3 halt
   int prog_op  [8];
   int prog_arg [8];
   int execs    [8];

   task automatic run_prog();
      int  p = 0;
      int  guard = 0;
      bit  br;
      for (int i = 0; i < 8; i++) execs[i] = 0;
      while (prog_op[p] != 3 && guard < 500) begin
         execs[p]++;
         step(prog_op[p] == 1, prog_op[p] == 2, p, prog_arg[p], prog_arg[p], br);
         p = br ? prog_arg[p] : p + 1;
         guard++;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      bit br;
      void'($urandom(32'd20240917));
      m_dep = 0; m_err = '0;
      repeat (3) @(posedge clk);
      do_reset();

      // R1: reset state
      check("R1 err_zero after reset", err_zero, 0);
      check("R1 err_overflow after reset", err_overflow, 0);
      check("R1 err_underflow after reset", err_underflow, 0);
      #1 check("R1 branch_take after reset", branch_take, 0);
      step(0, 1, 3, 0, 7, br);
      check("R1 empty stack close raises underflow", err_underflow, 1);

      // R6: nested program, inner 2 x outer 3, and a single-pass loop
      do_reset();
      prog_op = '{0, 1, 1, 2, 2, 1, 2, 3};
      prog_arg = '{0, 3, 2, 2, 1, 1, 5, 0};
      run_prog();
      check("R6 outer open runs n times", execs[1], 3);
      check("R6 inner open runs n*m times", execs[2], 6);
      check("R6 inner close runs n*m times", execs[3], 6);
      check("R6 outer close runs n times", execs[4], 3);
      check("R6 single-pass open", execs[5], 1);
      check("R6 single-pass close", execs[6], 1);
      check("R5 no error in clean program", err_underflow | err_zero | err_overflow, 0);

      // R3: re-entry ignores the new count
      do_reset();
      step(1, 0, 4, 2, 0, br);
      step(1, 0, 4, 9, 0, br);
      step(0, 1, 5, 0, 4, br);
      check("R3 first close branches", br, 1);
      step(0, 1, 5, 0, 4, br);
      check("R3 count kept at 2, second close falls through", br, 0);
      step(0, 1, 5, 0, 4, br);
      check("R5 frame popped, next close underflows", err_underflow, 1);

      // R12: lower-frame address is not matched
      do_reset();
      step(1, 0, 5, 1, 0, br);
      step(1, 0, 6, 1, 0, br);
      step(1, 0, 5, 2, 0, br);
      step(0, 1, 9, 0, 5, br);
      check("R12 new frame pushed over lower match", br, 1);

      // R8: full stack then ninth open
      do_reset();
      for (int i = 0; i < DEPTH; i++) step(1, 0, 10 + i, 2, 0, br);
      step(1, 0, 30, 3, 0, br);
      check("R8 ninth open flags overflow", err_overflow, 1);
      step(0, 1, 31, 0, 17, br);
      check("R8 top frame still eighth", br, 1);
      step(0, 1, 31, 0, 17, br);
      check("R8 eighth frame pops after two", br, 0);

      // R7 and R11: zero count, then sticky
      do_reset();
      step(1, 0, 2, 0, 0, br);
      check("R7 zero count flags", err_zero, 1);
      step(0, 1, 3, 0, 2, br);
      check("R7 zero count pushed nothing", err_underflow, 1);
      repeat (5) step(0, 0, 0, 0, 0, br);
      check("R11 err_zero sticky", err_zero, 1);

      // R4: wide count decrements
      do_reset();
      step(1, 0, 1, (1 << CNT_W) - 1, 0, br);
      step(0, 1, 2, 0, 1, br);
      check("R4 wide count branches", br, 1);

      // R10: both strobes
      do_reset();
      step(1, 0, 1, 2, 0, br);
      step(1, 1, 1, 2, 1, br);
      check("R10 close ignored", br, 0);
      step(0, 1, 2, 0, 1, br);
      check("R10 count untouched by ignored close", br, 1);

      // constrained random against the model
      do_reset();
      for (int n = 0; n < 3000; n++) begin
         int  r  = int'($urandom_range(9, 0));
         bit  l  = (r < 4) || (r == 8);
         bit  e  = (r >= 4 && r < 8) || (r == 8);
         int  c  = ($urandom_range(7, 0) == 0) ? 0 : int'($urandom_range(3, 1));
         if (n % 60 == 59) do_reset();
         step(l, e, int'($urandom_range(5, 0)), c, int'($urandom_range(5, 0)), br);
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule